// File: doc/BRIEF.md
# Flash Descriptor Readout Sequencer

This block answers a get-descriptor command by presenting a parameter descriptor of the flash array on one 32-bit result port. It presents one word at a time. Each read strobe moves on to the next word. The descriptor has a variable length. It starts with three fixed header words: the interface identifier, the total size and the page size. Next come the plane count and one size word per plane. Last come the lock-bit count and one size word per lock region. All values come from module parameters. When the planes or lock regions do not divide the total size evenly, the last entry of each list takes the remainder.

The result port is combinational from an internal word index, so the word shown in a cycle is the word consumed by a read strobe in that cycle. A get-descriptor command starts the stream again at word 0 at any point. Any other command ends the stream. After the stream ends, and before the first get-descriptor command, the port reads as zero. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `flash_desc_seq`

## Requirements
- R1: After reset, and until the first get-descriptor command, `rd_data` is zero and read strobes return zero.
- R2: After a get-descriptor command (code 0x0E), word 0 is `FLASH_ID`, word 1 is `FLASH_BYTES` and word 2 is `PAGE_BYTES`.
- R3: Word 3 is `NUM_PLANES`. It is followed by one word per plane. Each of these words is `FLASH_BYTES / NUM_PLANES` (integer division), except the last, which is `FLASH_BYTES` minus the sum of the others.
- R4: The word after the plane sizes is `NUM_LOCKS`. It is followed by one word per lock region, using the same split rule on `FLASH_BYTES` with `NUM_LOCKS` regions.
- R5: Each cycle with `rd_en` high and no command moves the stream forward by exactly one word. In cycles without `rd_en`, the presented word is held.
- R6: The stream is 5 + `NUM_PLANES` + `NUM_LOCKS` words long. After the last word, `rd_data` is zero and further reads return zero.
- R7: A get-descriptor command issued part-way through the stream restarts it at word 0.
- R8: A command with any code other than 0x0E ends the stream. Reads then return zero until the next get-descriptor command.
- R9: When a command and `rd_en` arrive in the same cycle, the command takes effect and the read does not advance the new stream. After a get-descriptor command this means word 0 is presented next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_code | input | CMD_W | Command code; 0x0E requests the descriptor |
| rd_en | input | 1 | Result-register read strobe |
| rd_data | output | 32 | Current descriptor word, or zero |

## Verification
The whole stream is read back to back, and every word is compared against values derived from the parameters. With three lock regions the last region size differs from the others, which separates a remainder-aware split from a plain division. Idle gaps between reads show that the index only moves on strobes. Restarts in the middle of the stream, a cancel by a foreign command code and a command arriving together with a read each exercise a different priority path. Extra reads past the end and before any command show the zero fill.

// File: rtl/fdesc_pkg.sv
package fdesc_pkg;

  localparam int WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  // Size of one entry when a total is split into n parts; the last part
  // carries whatever the integer division leaves over.
  function automatic word_t split_part(input word_t total, input word_t n, input logic last);
    word_t each;
    each = total / n;
    if (last) split_part = total - (each * (n - 1));
    else      split_part = each;
  endfunction

endpackage

// File: rtl/fdesc_rst_sync.sv
module fdesc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/fdesc_index.sv
module fdesc_index #(
  parameter int             LEN      = 10,
  parameter int             IDX_W    = 4,
  parameter int             CMD_W    = 8,
  parameter logic [CMD_W-1:0] GET_CODE = 8'h0E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             rd_en,
  output logic [IDX_W-1:0] idx,
  output logic             active
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEN);
  localparam logic [IDX_W-1:0] ONE      = IDX_W'(1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             act_q, act_d;
  logic             idx_en;
  logic             is_get;
  logic             step;

  assign is_get = cmd_valid && (cmd_code == GET_CODE);
  assign step   = rd_en && !cmd_valid && act_q && (idx_q != LAST_IDX);
  assign idx_en = cmd_valid || step;

  // next-state
  always_comb begin
    idx_d = idx_q;
    act_d = act_q;
    if (cmd_valid) begin
      idx_d = '0;
      act_d = is_get;
    end else if (step) begin
      idx_d = idx_q + ONE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      act_q <= 1'b0;
    end else if (idx_en) begin
      idx_q <= idx_d;
      act_q <= act_d;
    end
  end

  assign idx    = idx_q;
  assign active = act_q;

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX); // R6

  AST_GET_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == GET_CODE) |=> (idx_q == '0 && act_q)); // R7

  AST_OTHER_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code != GET_CODE) |=> !act_q); // R8

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !cmd_valid && act_q && idx_q != LAST_IDX) |=> (idx_q == $past(idx_q) + ONE)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !cmd_valid) |=> ($stable(idx_q) && $stable(act_q))); // R5

  AST_CMD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cmd_valid) |=> (idx_q == '0)); // R9

endmodule

// File: rtl/fdesc_words.sv
module fdesc_words
  import fdesc_pkg::*;
#(
  parameter int    IDX_W       = 4,
  parameter word_t FLASH_ID    = 32'h1D0C_0001,
  parameter word_t FLASH_BYTES = 32'd262144,
  parameter word_t PAGE_BYTES  = 32'd256,
  parameter int    NUM_PLANES  = 2,
  parameter int    NUM_LOCKS   = 3
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             active,
  output word_t            word
);

  localparam word_t PLANE_N    = word_t'(NUM_PLANES);
  localparam word_t LOCK_N     = word_t'(NUM_LOCKS);
  localparam word_t PLANE_EACH = split_part(FLASH_BYTES, PLANE_N, 1'b0);
  localparam word_t PLANE_LAST = split_part(FLASH_BYTES, PLANE_N, 1'b1);
  localparam word_t LOCK_EACH  = split_part(FLASH_BYTES, LOCK_N, 1'b0);
  localparam word_t LOCK_LAST  = split_part(FLASH_BYTES, LOCK_N, 1'b1);

  // word positions
  localparam logic [IDX_W-1:0] I_ID        = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_SIZE      = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_PAGE      = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_NPLANE    = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_PLANE_LO  = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_PLANE_END = IDX_W'(4 + NUM_PLANES - 1);
  localparam logic [IDX_W-1:0] I_NLOCK     = IDX_W'(4 + NUM_PLANES);
  localparam logic [IDX_W-1:0] I_LOCK_LO   = IDX_W'(5 + NUM_PLANES);
  localparam logic [IDX_W-1:0] I_LOCK_END  = IDX_W'(5 + NUM_PLANES + NUM_LOCKS - 1);

  logic in_planes;
  logic in_locks;

  assign in_planes = (idx >= I_PLANE_LO) && (idx <= I_PLANE_END);
  assign in_locks  = (idx >= I_LOCK_LO)  && (idx <= I_LOCK_END);

  always_comb begin
    word = '0;
    if (active) begin
      if (idx == I_ID)
        word = FLASH_ID;
      else if (idx == I_SIZE)
        word = FLASH_BYTES;
      else if (idx == I_PAGE)
        word = PAGE_BYTES;
      else if (idx == I_NPLANE)
        word = PLANE_N;
      else if (in_planes)
        word = (idx == I_PLANE_END) ? PLANE_LAST : PLANE_EACH;
      else if (idx == I_NLOCK)
        word = LOCK_N;
      else if (in_locks)
        word = (idx == I_LOCK_END) ? LOCK_LAST : LOCK_EACH;
    end
  end

endmodule

// File: rtl/flash_desc_seq.sv
module flash_desc_seq
  import fdesc_pkg::*;
#(
  parameter word_t            FLASH_ID    = 32'h1D0C_0001,
  parameter word_t            FLASH_BYTES = 32'd262144,
  parameter word_t            PAGE_BYTES  = 32'd256,
  parameter int               NUM_PLANES  = 2,
  parameter int               NUM_LOCKS   = 3,
  parameter int               CMD_W       = 8,
  parameter logic [CMD_W-1:0] GET_CODE    = 8'h0E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             rd_en,
  output logic [31:0]      rd_data
);

  localparam int LEN   = 5 + NUM_PLANES + NUM_LOCKS;
  localparam int IDX_W = $clog2(LEN + 1);

  logic             rst_n_s;
  logic [IDX_W-1:0] idx;
  logic             active;
  word_t            word;

  fdesc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  fdesc_index #(
    .LEN      (LEN),
    .IDX_W    (IDX_W),
    .CMD_W    (CMD_W),
    .GET_CODE (GET_CODE)
  ) u_index (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .rd_en     (rd_en),
    .idx       (idx),
    .active    (active)
  );

  fdesc_words #(
    .IDX_W       (IDX_W),
    .FLASH_ID    (FLASH_ID),
    .FLASH_BYTES (FLASH_BYTES),
    .PAGE_BYTES  (PAGE_BYTES),
    .NUM_PLANES  (NUM_PLANES),
    .NUM_LOCKS   (NUM_LOCKS)
  ) u_words (
    .idx    (idx),
    .active (active),
    .word   (word)
  );

  assign rd_data = word;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    !active |-> (rd_data == '0)); // R1

  AST_DRAINED_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (idx == IDX_W'(LEN)) |-> (rd_data == '0)); // R6

  AST_HEAD_ID: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_valid && cmd_code == GET_CODE) |=> (rd_data == FLASH_ID)); // R2

endmodule

// File: tb/flash_desc_seq_tb_top.sv
module flash_desc_seq_tb_top;

  localparam logic [31:0] T_ID    = 32'h1D0C_0001;
  localparam logic [31:0] T_FLASH = 32'd262144;
  localparam logic [31:0] T_PAGE  = 32'd256;
  localparam int          T_P     = 2;
  localparam int          T_L     = 3;
  localparam int          T_LEN   = 5 + T_P + T_L;
  localparam logic [7:0]  GET     = 8'h0E;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [7:0]  cmd_code;
  logic        rd_en;
  logic [31:0] rd_data;

  int checks;
  int errors;

  flash_desc_seq #(
    .FLASH_ID    (T_ID),
    .FLASH_BYTES (T_FLASH),
    .PAGE_BYTES  (T_PAGE),
    .NUM_PLANES  (T_P),
    .NUM_LOCKS   (T_L),
    .CMD_W       (8),
    .GET_CODE    (GET)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .rd_en     (rd_en),
    .rd_data   (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected word k, from the requirement text
  function automatic logic [31:0] exp_word(input int k);
    logic [31:0] v;
    v = 32'd0;
    if (k == 0) v = T_ID;
    else if (k == 1) v = T_FLASH;
    else if (k == 2) v = T_PAGE;
    else if (k == 3) v = 32'(T_P);
    else if (k < 4 + T_P)
      v = (k == 3 + T_P) ? T_FLASH - (T_FLASH / T_P) * (T_P - 1) : T_FLASH / T_P;
    else if (k == 4 + T_P) v = 32'(T_L);
    else if (k < T_LEN)
      v = (k == T_LEN - 1) ? T_FLASH - (T_FLASH / T_L) * (T_L - 1) : T_FLASH / T_L;
    return v;
  endfunction

  function automatic string req_of(input int k);
    if (k < 3) return "R2";
    if (k < 4 + T_P) return "R3";
    if (k < T_LEN) return "R4";
    return "R6";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] code);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    rd_en     = 1'b0;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic do_read(output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    #2 v = rd_data;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic t_idle;
    logic [31:0] v;
    @(negedge clk);
    chk("R1", rd_data, 32'd0);
    do_read(v); chk("R1", v, 32'd0);
    do_read(v); chk("R1", v, 32'd0);
  endtask

  task automatic t_full_stream;
    logic [31:0] v;
    send_cmd(GET);
    for (int k = 0; k < T_LEN; k++) begin
      do_read(v);
      chk(req_of(k), v, exp_word(k));
    end
    for (int k = 0; k < 3; k++) begin
      do_read(v);
      chk("R6", v, 32'd0);
    end
  endtask

  task automatic t_hold;
    logic [31:0] v;
    send_cmd(GET);
    do_read(v); chk("R5", v, exp_word(0));
    do_read(v); chk("R5", v, exp_word(1));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #2 chk("R5", rd_data, exp_word(2));
    end
    do_read(v); chk("R5", v, exp_word(2));
  endtask

  task automatic t_restart;
    logic [31:0] v;
    send_cmd(GET);
    for (int k = 0; k < 5; k++) do_read(v);
    send_cmd(GET);
    do_read(v); chk("R7", v, exp_word(0));
    do_read(v); chk("R7", v, exp_word(1));
  endtask

  task automatic t_cancel;
    logic [31:0] v;
    send_cmd(GET);
    do_read(v);
    do_read(v);
    send_cmd(8'h33);
    do_read(v); chk("R8", v, 32'd0);
    do_read(v); chk("R8", v, 32'd0);
    send_cmd(GET);
    do_read(v); chk("R8", v, exp_word(0));
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    send_cmd(GET);
    for (int k = 0; k < 3; k++) do_read(v);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = GET;
    rd_en     = 1'b1;
    @(posedge clk);
    #1 begin
      cmd_valid = 1'b0;
      rd_en     = 1'b0;
    end
    do_read(v); chk("R9", v, exp_word(0));
    do_read(v); chk("R9", v, exp_word(1));
  endtask

  initial begin
    checks    = 0;
    errors    = 0;
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_code  = 8'h00;
    rd_en     = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_idle();
    t_full_stream();
    t_hold();
    t_restart();
    t_cancel();
    t_same_cycle();
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule